// File: doc/BRIEF.md
# Integer Compare Flag Generator

This block computes one of four integer operations on two operands and produces four status flags from it: zero, sign, unsigned carry/borrow and signed overflow. A flag-write strobe controls whether the flags of the current operation are captured into a flags register. Only the captured flags feed the condition evaluator. The evaluator resolves a requested branch condition into a single condition-true bit. It covers signed orderings, unsigned orderings and equality.

A comparison works out the second operand minus the first (B − A) and keeps only the flags. One subtraction therefore provides both the borrow for unsigned orderings and the overflow for signed orderings. A later conditional step uses them together with the zero and sign flags. The test operation ANDs the operands and is used for zero and sign checks.

Top module: `cmp_flag_unit`

## Requirements
- R1: While reset is low, and after it, until the first strobed update, the registered flags zf_o, sf_o, cf_o and of_o are all 0.
- R2: For op_i = 0 (subtract), res_o equals b_i − a_i modulo 2^WIDTH. For op_i = 2 (add), res_o equals a_i + b_i modulo 2^WIDTH.
- R3: For op_i = 1 (compare) and op_i = 3 (test), res_o is all zeros. Only the flags carry the outcome.
- R4: The zero flag is set exactly when the computed value is zero. The sign flag equals the top bit of the computed value. This holds for all four operations, including compare and test, whose value is not output.
- R5: For subtract and compare, the carry flag is the borrow: it is set exactly when a_i > b_i as unsigned numbers. For add, it is the carry out of the top bit.
- R6: The overflow flag is set when the signed result of the operation does not fit in WIDTH bits. Examples: compare of a = 0x7FFF…F with b = 0x8000…0 gives value 1 with overflow 1 and carry 0. Adding −1 and −2 gives −3 with sign 1, carry 1 and overflow 0.
- R7: For test (op_i = 3), the value is a_i AND b_i, zero and sign follow that value, and carry and overflow are always 0.
- R8: The flags register loads the flags of the current operation on a rising clock edge only when flag_wr_i is 1. Otherwise it holds its value, whatever the operands and op.
- R9: Signed conditions on the registered flags use these codes: 1 = less-or-equal (SF xor OF, or ZF), 2 = less (SF xor OF), 3 = equal (ZF), 4 = not equal, 5 = greater-or-equal, 6 = greater. After a compare, each one matches the signed relation of b_i to a_i.
- R10: Unsigned conditions use these codes: 7 = below (CF), 8 = below-or-equal (CF or ZF), 9 = above (not CF and not ZF), 10 = above-or-equal (not CF). After a compare, each one matches the unsigned relation of b_i to a_i.
- R11: Condition code 0 is always true. Codes 11 to 15 are always false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | First operand (subtrahend for subtract/compare) |
| b_i | input | WIDTH | Second operand (minuend for subtract/compare) |
| op_i | input | 2 | 0 subtract, 1 compare, 2 add, 3 test |
| cond_i | input | 4 | Condition code to evaluate |
| flag_wr_i | input | 1 | Capture flags of the current operation at the next edge |
| res_o | output | WIDTH | Operation result (zero for compare and test) |
| zf_o | output | 1 | Registered zero flag |
| sf_o | output | 1 | Registered sign flag |
| cf_o | output | 1 | Registered carry/borrow flag |
| of_o | output | 1 | Registered signed overflow flag |
| cond_true_o | output | 1 | Selected condition holds on the registered flags |

## Verification
The clocked properties assume that the operands, op_i, cond_i and flag_wr_i are known and settled at every rising edge once reset is released. The bench meets this by changing inputs only on the falling edge and by never driving X or Z. The borrow and zero properties compare the operands directly and apply only to the subtract and compare codes. The bench therefore checks add and test flags through its own model. The operand pairs for compare include sign-crossing extremes, so that overflow and borrow disagree with the plain sign of the result.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

   typedef enum logic [1:0] {
      OP_SUB  = 2'd0,
      OP_CMP  = 2'd1,
      OP_ADD  = 2'd2,
      OP_TEST = 2'd3
   } cfu_op_e;

   typedef enum logic [3:0] {
      CC_ALWAYS = 4'd0,
      CC_LE     = 4'd1,
      CC_LT     = 4'd2,
      CC_EQ     = 4'd3,
      CC_NE     = 4'd4,
      CC_GE     = 4'd5,
      CC_GT     = 4'd6,
      CC_ULT    = 4'd7,
      CC_ULE    = 4'd8,
      CC_UGT    = 4'd9,
      CC_UGE    = 4'd10
   } cfu_cc_e;

   typedef struct packed {
      logic zf;
      logic sf;
      logic cf;
      logic of;
   } cfu_flags_t;

endpackage

// File: rtl/cfu_alu.sv
module cfu_alu
   import cfu_pkg::*;
#(
   parameter int WIDTH        = 64,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  cfu_op_e          op_i,
   output logic [WIDTH-1:0] value_o,
   output cfu_flags_t       flags_o
);

   localparam int MSB = WIDTH - 1;

   logic             is_sub;
   logic [WIDTH-1:0] arith;
   logic             cf_arith;
   logic             of_arith;
   logic [WIDTH-1:0] val;

   assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

   generate
      if (SHARED_ADDER) begin : g_shared
         // one adder: b + ~a + 1 for subtraction, b + a for addition
         logic [WIDTH:0]   sum;
         logic [WIDTH-1:0] addend;
         always_comb begin
            addend   = is_sub ? ~a_i : a_i;
            sum      = {1'b0, b_i} + {1'b0, addend} + {{WIDTH{1'b0}}, is_sub};
            arith    = sum[WIDTH-1:0];
            // carry out of b + ~a + 1 is the inverse of the borrow
            cf_arith = is_sub ? ~sum[WIDTH] : sum[WIDTH];
         end
      end else begin : g_split
         // separate subtractor and adder, selected afterwards
         logic [WIDTH:0] diff;
         logic [WIDTH:0] total;
         always_comb begin
            diff     = {1'b0, b_i} - {1'b0, a_i};
            total    = {1'b0, a_i} + {1'b0, b_i};
            arith    = is_sub ? diff[WIDTH-1:0] : total[WIDTH-1:0];
            cf_arith = is_sub ? diff[WIDTH] : total[WIDTH];
         end
      end
   endgenerate

   always_comb begin
      if (is_sub)
         of_arith = (a_i[MSB] ^ b_i[MSB]) & (arith[MSB] ^ b_i[MSB]);
      else
         of_arith = ~(a_i[MSB] ^ b_i[MSB]) & (arith[MSB] ^ a_i[MSB]);
   end

   always_comb begin
      val        = (op_i == OP_TEST) ? (a_i & b_i) : arith;
      value_o    = val;
      flags_o.zf = (val == '0);
      flags_o.sf = val[MSB];
      flags_o.cf = (op_i == OP_TEST) ? 1'b0 : cf_arith;
      flags_o.of = (op_i == OP_TEST) ? 1'b0 : of_arith;
   end

endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
   import cfu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  cfu_flags_t d_i,
   output cfu_flags_t q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (wr_i)
         q_o <= d_i;
   end

   // R1: reset leaves the register cleared
   p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> q_o == '0)
      else $error("flags not cleared by reset");

   // R8: no strobe, no change
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> q_o == $past(q_o))
      else $error("flags changed without strobe");

   // R8: strobe captures the flags presented at that edge
   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> q_o == $past(d_i))
      else $error("flags not loaded on strobe");

endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
   import cfu_pkg::*;
(
   input  cfu_flags_t fl_i,
   input  logic [3:0] cc_i,
   output logic       hit_o
);

   logic lt_s;

   assign lt_s = fl_i.sf ^ fl_i.of;

   always_comb begin
      unique case (cfu_cc_e'(cc_i))
         CC_ALWAYS: hit_o = 1'b1;
         CC_LE:     hit_o = lt_s | fl_i.zf;
         CC_LT:     hit_o = lt_s;
         CC_EQ:     hit_o = fl_i.zf;
         CC_NE:     hit_o = ~fl_i.zf;
         CC_GE:     hit_o = ~lt_s;
         CC_GT:     hit_o = ~lt_s & ~fl_i.zf;
         CC_ULT:    hit_o = fl_i.cf;
         CC_ULE:    hit_o = fl_i.cf | fl_i.zf;
         CC_UGT:    hit_o = ~fl_i.cf & ~fl_i.zf;
         CC_UGE:    hit_o = ~fl_i.cf;
         default:   hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
   import cfu_pkg::*;
#(
   parameter int WIDTH        = 64,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       op_i,
   input  logic [3:0]       cond_i,
   input  logic             flag_wr_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zf_o,
   output logic             sf_o,
   output logic             cf_o,
   output logic             of_o,
   output logic             cond_true_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cmp_flag_unit: WIDTH must be at least 2");
      end
   endgenerate

   cfu_op_e          op;
   logic [WIDTH-1:0] alu_val;
   cfu_flags_t       alu_fl;
   cfu_flags_t       reg_fl;

   assign op = cfu_op_e'(op_i);

   cfu_alu #(
      .WIDTH       (WIDTH),
      .SHARED_ADDER(SHARED_ADDER)
   ) u_alu (
      .a_i    (a_i),
      .b_i    (b_i),
      .op_i   (op),
      .value_o(alu_val),
      .flags_o(alu_fl)
   );

   cfu_flag_reg u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_i (flag_wr_i),
      .d_i  (alu_fl),
      .q_o  (reg_fl)
   );

   cfu_cond_eval u_cond (
      .fl_i (reg_fl),
      .cc_i (cond_i),
      .hit_o(cond_true_o)
   );

   assign res_o = ((op == OP_CMP) || (op == OP_TEST)) ? '0 : alu_val;
   assign zf_o  = reg_fl.zf;
   assign sf_o  = reg_fl.sf;
   assign cf_o  = reg_fl.cf;
   assign of_o  = reg_fl.of;

   // R3: compare and test never drive a result
   p_quiet_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd1 || op_i == 2'd3) |-> res_o == '0)
      else $error("compare/test drove a result");

   // R5: borrow equals unsigned a > b
   p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd0 || op_i == 2'd1) |-> alu_fl.cf == (a_i > b_i))
      else $error("borrow mismatch");

   // R4: zero after subtraction means equal operands
   p_zero_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd0 || op_i == 2'd1) |-> alu_fl.zf == (a_i == b_i))
      else $error("zero flag mismatch");

   // R7: test clears carry and overflow
   p_test_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 2'd3 |-> !alu_fl.cf && !alu_fl.of)
      else $error("test left carry/overflow set");

   // R9: equal condition tracks the registered zero flag
   p_eq_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i == 4'd3 |-> cond_true_o == zf_o)
      else $error("equal condition mismatch");

   // R11: reserved codes never hit
   p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i > 4'd10 |-> !cond_true_o)
      else $error("reserved condition hit");

endmodule

// File: tb/cmp_flag_unit_test.sv
module cmp_flag_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] a, b;
   logic [1:0]  op;
   logic [3:0]  cc;
   logic        wr;
   logic [63:0] res;
   logic        zf, sf, cf, of, hit;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   cmp_flag_unit #(.WIDTH(64)) uut (
      .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .op_i(op), .cond_i(cc),
      .flag_wr_i(wr), .res_o(res), .zf_o(zf), .sf_o(sf), .cf_o(cf),
      .of_o(of), .cond_true_o(hit)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected flags {zf,sf,cf,of}
   function automatic logic [3:0] mflags(input logic [63:0] x, input logic [63:0] y,
                                         input logic [1:0] o);
      logic [63:0]        v;
      logic signed [64:0] s;
      logic [64:0]        u;
      logic               c, ov;
      case (o)
         2'd0, 2'd1: begin
            v  = y - x;
            s  = $signed({y[63], y}) - $signed({x[63], x});
            c  = (x > y);
            ov = (s[64] != s[63]);
         end
         2'd2: begin
            v  = x + y;
            s  = $signed({x[63], x}) + $signed({y[63], y});
            u  = {1'b0, x} + {1'b0, y};
            c  = u[64];
            ov = (s[64] != s[63]);
         end
         default: begin
            v  = x & y;
            c  = 1'b0;
            ov = 1'b0;
         end
      endcase
      return {v == 64'd0, v[63], c, ov};
   endfunction

   function automatic logic [63:0] mres(input logic [63:0] x, input logic [63:0] y,
                                        input logic [1:0] o);
      case (o)
         2'd0:    return y - x;
         2'd2:    return x + y;
         default: return 64'd0;
      endcase
   endfunction

   // expected condition after a compare of x against y (value = y - x)
   function automatic logic mcond(input logic [63:0] x, input logic [63:0] y,
                                  input int c);
      case (c)
         0:  return 1'b1;
         1:  return $signed(y) <= $signed(x);
         2:  return $signed(y) <  $signed(x);
         3:  return y == x;
         4:  return y != x;
         5:  return $signed(y) >= $signed(x);
         6:  return $signed(y) >  $signed(x);
         7:  return y <  x;
         8:  return y <= x;
         9:  return y >  x;
         10: return y >= x;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk_flags(input logic [3:0] exp, input logic [1:0] o);
      chk(o == 2'd3 ? "R7 zf" : "R4 zf", {63'd0, zf}, {63'd0, exp[3]});
      chk(o == 2'd3 ? "R7 sf" : "R4 sf", {63'd0, sf}, {63'd0, exp[2]});
      chk(o == 2'd3 ? "R7 cf" : "R5 cf", {63'd0, cf}, {63'd0, exp[1]});
      chk(o == 2'd3 ? "R7 of" : "R6 of", {63'd0, of}, {63'd0, exp[0]});
   endtask

   // drive at falling edge, check result, then flags one edge later
   task automatic run_op(input logic [63:0] x, input logic [63:0] y,
                         input logic [1:0] o, input logic w);
      @(negedge clk);
      a = x; b = y; op = o; wr = w;
      #1;
      chk((o == 2'd1 || o == 2'd3) ? "R3 result" : "R2 result", res, mres(x, y, o));
      if (w) begin
         @(negedge clk);
         wr = 1'b0;
         #1;
         chk_flags(mflags(x, y, o), o);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; a = '0; b = '0; op = 2'd0; cc = 4'd0; wr = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 flags", {60'd0, zf, sf, cf, of}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after release", {60'd0, zf, sf, cf, of}, 64'd0);
      cc = 4'd0; #1;
      chk("R11 always", {63'd0, hit}, 64'd1);
      cc = 4'd15; #1;
      chk("R11 reserved", {63'd0, hit}, 64'd0);
      cc = 4'd2; #1;
      chk("R9 lt on cleared flags", {63'd0, hit}, 64'd0);
   endtask

   task automatic t_examples();
      run_op(-64'sd10, 64'd20, 2'd1, 1'b1);
      chk("R5 borrow example", {63'd0, cf}, 64'd1);
      run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 2'd1, 1'b1);
      chk("R6 overflow example", {62'd0, of, cf}, 64'd2);
      run_op(-64'sd1, -64'sd2, 2'd2, 1'b1);
      chk("R6 add example", {60'd0, zf, sf, cf, of}, 64'b0110);
      run_op(64'd5, 64'd5, 2'd0, 1'b1);
      run_op(64'd10, 64'd3, 2'd0, 1'b1);
      run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd2, 1'b1);
   endtask

   task automatic t_test_op();
      run_op(-64'sd10, 64'd20, 2'd1, 1'b1);    // leaves CF set
      run_op(64'h0000_00F0, 64'h0000_000F, 2'd3, 1'b1);
      chk("R7 test zero", {60'd0, zf, sf, cf, of}, 64'b1000);
      run_op(64'hF000_0000_0000_0001, 64'h8000_0000_0000_0003, 2'd3, 1'b1);
      chk("R7 test sign", {60'd0, zf, sf, cf, of}, 64'b0100);
   endtask

   task automatic t_hold();
      logic [3:0] kept;
      run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 2'd1, 1'b1);
      kept = {zf, sf, cf, of};
      run_op(64'd7, 64'd7, 2'd0, 1'b0);
      @(negedge clk);
      chk("R8 hold after sub", {60'd0, zf, sf, cf, of}, {60'd0, kept});
      run_op(-64'sd1, -64'sd2, 2'd2, 1'b0);
      @(negedge clk);
      chk("R8 hold after add", {60'd0, zf, sf, cf, of}, {60'd0, kept});
      cc = 4'd2; #1;
      chk("R8 cond uses held flags", {63'd0, hit}, 64'd1);
   endtask

   task automatic t_conds();
      logic [63:0] pa [8];
      logic [63:0] pb [8];
      pa[0] = 64'd5;                    pb[0] = 64'd5;
      pa[1] = 64'd3;                    pb[1] = 64'd10;
      pa[2] = 64'd10;                   pb[2] = 64'd3;
      pa[3] = -64'sd10;                 pb[3] = 64'd20;
      pa[4] = 64'd20;                   pb[4] = -64'sd10;
      pa[5] = 64'h7FFF_FFFF_FFFF_FFFF;  pb[5] = 64'h8000_0000_0000_0000;
      pa[6] = 64'h8000_0000_0000_0000;  pb[6] = 64'h7FFF_FFFF_FFFF_FFFF;
      pa[7] = 64'd0;                    pb[7] = 64'hFFFF_FFFF_FFFF_FFFF;
      for (int i = 0; i < 8; i++) begin
         run_op(pa[i], pb[i], 2'd1, 1'b1);
         for (int c = 0; c < 16; c++) begin
            cc = c[3:0];
            #1;
            chk(c <= 6 ? "R9 signed cond" : (c <= 10 ? "R10 unsigned cond" : "R11 fixed cond"),
                {63'd0, hit}, {63'd0, mcond(pa[i], pb[i], c)});
         end
      end
      cc = 4'd0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_examples();
      t_test_op();
      t_hold();
      t_conds();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule